// File: doc/BRIEF.md
# Channel Setup and Clock-Lock Sequencer

This block watches the reconfiguration messages that a bus manager sends to one data port. It decides when the audio master clocks for that port must be programmed, and it decides when sample streaming may begin. A message decoder ahead of it turns each received message into a one-cycle event strobe. The block groups these strobes into reconfiguration transactions. A transaction opens with a begin strobe and takes effect only when a commit strobe closes it.

Clock programming starts when a committed transaction defines both the channel structure and the channel content. It does not wait for activation. Clocks made by the internal PLL then settle for a fixed number of millisecond ticks before the block reports them ready. External clocks are taken as stable at once. A later transaction activates the channel. Streaming is enabled only when the port is connected, the channel is active and the clocks are ready. Deactivation leaves the clock setup in place. Only a port reset removes it.

Top module: `chan_lock_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cfg_pulse`, `clk_ready` and `stream_en` are all 0.
- R2: A commit that closes an open transaction containing both a define-channel and a define-content event, on a connected port, raises `cfg_pulse` for exactly one cycle, in the cycle after the commit is sampled. A commit whose transaction holds only one of the two defines, or one on a port that is not connected, gives no pulse.
- R3: With `ext_clk_sel` low at the commit, `clk_ready` drops at the configure launch. It rises in the cycle after the SETTLE_TICKS-th (default 3) `ms_tick` that is sampled after the launch edge, and not earlier.
- R4: `stream_en` rises in the cycle after the port is connected, the channel is active and `clk_ready` is high all at once. An activation committed before the clocks are ready waits for them.
- R5: A committed deactivation lowers `stream_en` one cycle after the commit is sampled and leaves `clk_ready` unchanged. A later committed activation restores `stream_en` one cycle after its commit, with no new `cfg_pulse`.
- R6: `ev_port_reset` clears `clk_ready` and `stream_en` at the edge that samples it, and it disconnects the port. Activation or definition afterwards yields neither streaming nor a pulse until the port is connected again.
- R7: With `ext_clk_sel` high at the commit, `clk_ready` is set in the same cycle as `cfg_pulse`, with no settling wait.
- R8: Define, activate, deactivate and commit events that arrive while no transaction is open are ignored. A begin that arrives while a transaction is open discards the unfinished one.
- R9: Redefining an already configured channel launches the clocks again. `cfg_pulse` fires, `clk_ready` and `stream_en` drop at that edge, and streaming resumes after the new settling period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_conn_src | input | 1 | Strobe: port connected as a source |
| ev_conn_snk | input | 1 | Strobe: port connected as a sink |
| ev_begin | input | 1 | Strobe: reconfiguration transaction opens |
| ev_def_chan | input | 1 | Strobe: channel structure defined |
| ev_def_cont | input | 1 | Strobe: channel content defined |
| ev_activate | input | 1 | Strobe: channel activation requested |
| ev_deactivate | input | 1 | Strobe: channel deactivation requested |
| ev_commit | input | 1 | Strobe: open transaction takes effect |
| ev_port_reset | input | 1 | Strobe: port reset, highest priority |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| ext_clk_sel | input | 1 | 1 = external audio clocks, 0 = internal PLL |
| cfg_pulse | output | 1 | One-cycle request to program the audio clocks |
| clk_ready | output | 1 | Audio clocks settled |
| stream_en | output | 1 | Sample streaming permitted |

## Verification
`cfg_pulse`, `clk_ready` and a port-reset drop of `stream_en` all appear one edge after the commit or reset strobe is sampled. A settled `clk_ready` appears one edge after the last counted tick. A rise or a deactivation drop of `stream_en` comes one edge later again, because it is registered from the state those events set. The bench drives every strobe for exactly one clock and samples on the falling edge that follows. It checks each result at the precise falling edge where it is due, and it checks one edge earlier where the lag itself is what the requirement states.

// File: rtl/chls_pkg.sv
package chls_pkg;

  // Changes collected inside one open reconfiguration transaction
  typedef struct packed {
    logic chan;
    logic cont;
    logic act;
    logic deact;
  } chls_pend_t;

  typedef enum logic [1:0] {
    TMR_IDLE   = 2'd0,
    TMR_WAIT   = 2'd1,
    TMR_LOCKED = 2'd2
  } chls_tmr_e;

endpackage

// File: rtl/chls_txn_track.sv
module chls_txn_track
  import chls_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       port_rst_i,
  input  logic       begin_i,
  input  logic       def_chan_i,
  input  logic       def_cont_i,
  input  logic       act_i,
  input  logic       deact_i,
  input  logic       commit_i,
  output logic       commit_vld_o,
  output chls_pend_t commit_o
);

  logic       open_q;
  chls_pend_t pend_q;

  always_ff @(posedge clk) begin
    if (rst || port_rst_i) begin
      open_q <= 1'b0;
      pend_q <= '0;
    end else if (begin_i) begin
      // a fresh begin drops whatever was still pending
      open_q <= 1'b1;
      pend_q <= '0;
    end else if (open_q) begin
      if (commit_i) begin
        open_q <= 1'b0;
        pend_q <= '0;
      end else begin
        if (def_chan_i) pend_q.chan <= 1'b1;
        if (def_cont_i) pend_q.cont <= 1'b1;
        if (act_i) begin
          pend_q.act   <= 1'b1;
          pend_q.deact <= 1'b0;
        end
        if (deact_i) begin
          pend_q.deact <= 1'b1;
          pend_q.act   <= 1'b0;
        end
      end
    end
  end

  assign commit_vld_o = open_q && commit_i && !begin_i;
  assign commit_o     = pend_q;

  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!open_q && !begin_i && !port_rst_i) |=> (pend_q == '0)) // R8
    else $error("stray event changed pending state");

  AST_NO_COMMIT_CLOSED: assert property (@(posedge clk) disable iff (rst)
    commit_vld_o |=> !commit_vld_o) // R8
    else $error("commit accepted twice in a row");

endmodule

// File: rtl/chls_settle_timer.sv
module chls_settle_timer
  import chls_pkg::*;
#(
  parameter int SETTLE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic launch_i,
  input  logic ext_i,
  input  logic tick_i,
  output logic ready_o
);

  localparam int CNT_W = (SETTLE_TICKS < 2) ? 1 : $clog2(SETTLE_TICKS);

  generate
    if (SETTLE_TICKS == 0) begin : g_no_wait
      logic unused_tick;
      assign unused_tick = tick_i ^ ext_i;
      always_ff @(posedge clk) begin
        if (rst || clr_i) ready_o <= 1'b0;
        else if (launch_i) ready_o <= 1'b1;
      end
    end else begin : g_wait
      localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);
      chls_tmr_e        st_q;
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || clr_i) begin
          st_q    <= TMR_IDLE;
          cnt_q   <= '0;
          ready_o <= 1'b0;
        end else if (launch_i) begin
          cnt_q <= '0;
          if (ext_i) begin
            st_q    <= TMR_LOCKED;
            ready_o <= 1'b1;
          end else begin
            st_q    <= TMR_WAIT;
            ready_o <= 1'b0;
          end
        end else if (st_q == TMR_WAIT && tick_i) begin
          if (cnt_q == LAST) begin
            st_q    <= TMR_LOCKED;
            cnt_q   <= '0;
            ready_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end

      AST_READY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> ($past(launch_i && ext_i) || $past(tick_i && st_q == TMR_WAIT))) // R3
        else $error("ready rose without ext launch or final tick");

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST) // R3
        else $error("settle counter out of range");
    end
  endgenerate

endmodule

// File: rtl/chls_stream_gate.sv
module chls_stream_gate
  import chls_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       port_rst_i,
  input  logic       conn_i,
  input  logic       commit_vld_i,
  input  chls_pend_t commit_i,
  input  logic       launch_i,
  input  logic       ready_i,
  output logic       connected_o,
  output logic       stream_o
);

  logic active_q;

  always_ff @(posedge clk) begin
    if (rst || port_rst_i) begin
      connected_o <= 1'b0;
      active_q    <= 1'b0;
    end else begin
      if (conn_i) connected_o <= 1'b1;
      if (commit_vld_i) begin
        if (commit_i.deact)    active_q <= 1'b0;
        else if (commit_i.act) active_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stream_o <= 1'b0;
    else     stream_o <= connected_o && active_q && ready_i && !launch_i && !port_rst_i;
  end

  AST_STREAM_CONNECTED: assert property (@(posedge clk) disable iff (rst)
    stream_o |-> connected_o) // R4
    else $error("streaming on a disconnected port");

endmodule

// File: rtl/chan_lock_seq.sv
module chan_lock_seq
  import chls_pkg::*;
#(
  parameter int SETTLE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_conn_src,
  input  logic ev_conn_snk,
  input  logic ev_begin,
  input  logic ev_def_chan,
  input  logic ev_def_cont,
  input  logic ev_activate,
  input  logic ev_deactivate,
  input  logic ev_commit,
  input  logic ev_port_reset,
  input  logic ms_tick,
  input  logic ext_clk_sel,
  output logic cfg_pulse,
  output logic clk_ready,
  output logic stream_en
);

  logic       commit_vld;
  chls_pend_t commit_set;
  logic       connected;
  logic       launch;

  chls_txn_track i_track (
    .clk          (clk),
    .rst          (rst),
    .port_rst_i   (ev_port_reset),
    .begin_i      (ev_begin),
    .def_chan_i   (ev_def_chan),
    .def_cont_i   (ev_def_cont),
    .act_i        (ev_activate),
    .deact_i      (ev_deactivate),
    .commit_i     (ev_commit),
    .commit_vld_o (commit_vld),
    .commit_o     (commit_set)
  );

  assign launch = commit_vld && commit_set.chan && commit_set.cont
                  && connected && !ev_port_reset;

  always_ff @(posedge clk) begin
    if (rst) cfg_pulse <= 1'b0;
    else     cfg_pulse <= launch;
  end

  chls_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (ev_port_reset),
    .launch_i (launch),
    .ext_i    (ext_clk_sel),
    .tick_i   (ms_tick),
    .ready_o  (clk_ready)
  );

  chls_stream_gate i_gate (
    .clk          (clk),
    .rst          (rst),
    .port_rst_i   (ev_port_reset),
    .conn_i       (ev_conn_src || ev_conn_snk),
    .commit_vld_i (commit_vld),
    .commit_i     (commit_set),
    .launch_i     (launch),
    .ready_i      (clk_ready),
    .connected_o  (connected),
    .stream_o     (stream_en)
  );

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cfg_pulse |=> !cfg_pulse) // R2
    else $error("configure pulse longer than one cycle");

  AST_STREAM_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    stream_en |-> clk_ready) // R4
    else $error("streaming without settled clocks");

  AST_PRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(ev_port_reset) |-> (!clk_ready && !stream_en)) // R6
    else $error("port reset left clocks or streaming on");

  AST_DEACT_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
    (commit_vld && commit_set.deact && !commit_set.chan && clk_ready && !ev_port_reset)
      |=> clk_ready) // R5
    else $error("deactivation dropped clock readiness");

  AST_EXT_READY_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cfg_pulse && $past(ext_clk_sel)) |-> clk_ready) // R7
    else $error("external clocks not ready with the pulse");

endmodule

// File: tb/test_chan_lock_seq.sv
module test_chan_lock_seq;

  localparam int EV_SRC = 0, EV_SNK = 1, EV_BEGIN = 2, EV_DCH = 3, EV_DCT = 4,
                 EV_ACT = 5, EV_DEACT = 6, EV_COMMIT = 7, EV_PRST = 8, EV_TICK = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_conn_src = 0, ev_conn_snk = 0, ev_begin = 0, ev_def_chan = 0;
  logic ev_def_cont = 0, ev_activate = 0, ev_deactivate = 0, ev_commit = 0;
  logic ev_port_reset = 0, ms_tick = 0, ext_clk_sel = 0;
  logic cfg_pulse, clk_ready, stream_en;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  chan_lock_seq i_chan_lock_seq (
    .clk(clk), .rst(rst),
    .ev_conn_src(ev_conn_src), .ev_conn_snk(ev_conn_snk), .ev_begin(ev_begin),
    .ev_def_chan(ev_def_chan), .ev_def_cont(ev_def_cont), .ev_activate(ev_activate),
    .ev_deactivate(ev_deactivate), .ev_commit(ev_commit), .ev_port_reset(ev_port_reset),
    .ms_tick(ms_tick), .ext_clk_sel(ext_clk_sel),
    .cfg_pulse(cfg_pulse), .clk_ready(clk_ready), .stream_en(stream_en)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic set_ev(input int code, input logic v);
    case (code)
      EV_SRC:    ev_conn_src   = v;
      EV_SNK:    ev_conn_snk   = v;
      EV_BEGIN:  ev_begin      = v;
      EV_DCH:    ev_def_chan   = v;
      EV_DCT:    ev_def_cont   = v;
      EV_ACT:    ev_activate   = v;
      EV_DEACT:  ev_deactivate = v;
      EV_COMMIT: ev_commit     = v;
      EV_PRST:   ev_port_reset = v;
      default:   ms_tick       = v;
    endcase
  endtask

  // drive one strobe for one clock; returns at the falling edge after it was sampled
  task automatic send(input int code);
    set_ev(code, 1'b1);
    @(posedge clk);
    @(negedge clk);
    set_ev(code, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "pulse in reset", cfg_pulse, 1'b0);
    chk("R1", "ready in reset", clk_ready, 1'b0);
    chk("R1", "stream in reset", stream_en, 1'b0);
    rst = 1'b0;
    idle(1);
    chk("R1", "ready after reset", clk_ready, 1'b0);
    chk("R1", "stream after reset", stream_en, 1'b0);
  endtask

  task automatic t_pll_flow;
    ext_clk_sel = 1'b0;
    send(EV_SRC); send(EV_BEGIN); send(EV_DCH); send(EV_DCT);
    chk("R2", "no pulse before commit", cfg_pulse, 1'b0);
    send(EV_COMMIT);
    chk("R2", "pulse after define commit", cfg_pulse, 1'b1);
    chk("R3", "not ready at launch", clk_ready, 1'b0);
    idle(1);
    chk("R2", "pulse lasts one cycle", cfg_pulse, 1'b0);
    send(EV_TICK); send(EV_TICK);
    chk("R3", "not ready after two ticks", clk_ready, 1'b0);
    send(EV_TICK);
    chk("R3", "ready after third tick", clk_ready, 1'b1);
    send(EV_BEGIN); send(EV_ACT); send(EV_COMMIT);
    chk("R4", "stream lags activation", stream_en, 1'b0);
    idle(1);
    chk("R4", "stream after activation", stream_en, 1'b1);
  endtask

  task automatic t_deact;
    send(EV_BEGIN); send(EV_DEACT); send(EV_COMMIT);
    chk("R5", "ready kept on deactivate", clk_ready, 1'b1);
    idle(1);
    chk("R5", "stream off after deactivate", stream_en, 1'b0);
    chk("R5", "ready still kept", clk_ready, 1'b1);
    send(EV_BEGIN); send(EV_ACT); send(EV_COMMIT);
    chk("R5", "no pulse on reactivation", cfg_pulse, 1'b0);
    idle(1);
    chk("R5", "stream back at once", stream_en, 1'b1);
  endtask

  task automatic t_redefine;
    send(EV_BEGIN); send(EV_DCH); send(EV_DCT); send(EV_COMMIT);
    chk("R9", "pulse on redefine", cfg_pulse, 1'b1);
    chk("R9", "ready drops on redefine", clk_ready, 1'b0);
    chk("R9", "stream drops on redefine", stream_en, 1'b0);
    send(EV_TICK); send(EV_TICK); send(EV_TICK);
    chk("R9", "ready after new settle", clk_ready, 1'b1);
    idle(1);
    chk("R9", "stream resumes", stream_en, 1'b1);
  endtask

  task automatic t_port_reset;
    send(EV_PRST);
    chk("R6", "ready cleared", clk_ready, 1'b0);
    chk("R6", "stream cleared", stream_en, 1'b0);
    send(EV_BEGIN); send(EV_ACT); send(EV_COMMIT);
    idle(1);
    chk("R6", "no stream after reset", stream_en, 1'b0);
    send(EV_BEGIN); send(EV_DCH); send(EV_DCT); send(EV_COMMIT);
    chk("R6", "no pulse on disconnected port", cfg_pulse, 1'b0);
  endtask

  task automatic t_early_act;
    send(EV_PRST);
    send(EV_SNK); send(EV_BEGIN); send(EV_DCH); send(EV_DCT); send(EV_ACT); send(EV_COMMIT);
    chk("R2", "pulse with early activation", cfg_pulse, 1'b1);
    send(EV_TICK); send(EV_TICK);
    chk("R4", "no stream while settling", stream_en, 1'b0);
    send(EV_TICK);
    chk("R4", "ready after settle", clk_ready, 1'b1);
    chk("R4", "stream still lags ready", stream_en, 1'b0);
    idle(1);
    chk("R4", "stream after settle", stream_en, 1'b1);
  endtask

  task automatic t_stray;
    send(EV_PRST);
    send(EV_SRC);
    send(EV_DCH); send(EV_DCT); send(EV_COMMIT);
    chk("R8", "commit without begin ignored", cfg_pulse, 1'b0);
    send(EV_BEGIN); send(EV_DCH); send(EV_DCT); send(EV_BEGIN); send(EV_COMMIT);
    chk("R8", "abandoned transaction discarded", cfg_pulse, 1'b0);
    send(EV_BEGIN); send(EV_DCH); send(EV_COMMIT);
    send(EV_BEGIN); send(EV_DCT); send(EV_COMMIT);
    chk("R2", "split defines do not launch", cfg_pulse, 1'b0);
    chk("R8", "ready stays low", clk_ready, 1'b0);
  endtask

  task automatic t_external;
    send(EV_PRST);
    ext_clk_sel = 1'b1;
    send(EV_SRC); send(EV_BEGIN); send(EV_DCH); send(EV_DCT); send(EV_COMMIT);
    chk("R7", "pulse with external clocks", cfg_pulse, 1'b1);
    chk("R7", "ready with pulse", clk_ready, 1'b1);
    send(EV_BEGIN); send(EV_ACT); send(EV_COMMIT);
    idle(1);
    chk("R7", "stream without settling", stream_en, 1'b1);
    ext_clk_sel = 1'b0;
  endtask

  initial begin
    idle(3);
    t_reset();
    t_pll_flow();
    t_deact();
    t_redefine();
    t_port_reset();
    t_early_act();
    t_stray();
    t_external();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule